// File: doc/BRIEF.md
# Security-banked interrupt control and state register

This block is the control and status word of a small exception controller that runs code in two security states, secure and non-secure. Software reads it to learn which exception is running, which exception is next in line, and whether a return would drop back to thread level. It writes it to raise or drop the pend request of three system exceptions: the system timer, the deferred service call (PendSV) and the non-maskable interrupt (NMI).

Timer and PendSV pend flags are kept as two copies, one per security state. The security attribute carried by each bus access chooses the copy that is read and the copy that is written. NMI pend control has a single copy and is reachable only while a separate visibility control input is high; that input lets non-secure software see NMI and fault control. An NMI clear bit exists only when the block is built for the newer architecture mode (parameter `NEWER_MODE`). Priority arbitration, vector fetch and exception entry and return sit outside this block. The active and pending vector numbers and the single-active flag arrive as inputs. The pend flops go out as outputs to the arbiter.

Top module: `ctrl_state_reg`

## Requirements
- R1: After reset every pend flag (timer and PendSV in both copies, and NMI) is 0, and a read at the register address returns only the status input fields.
- R2: A read at byte address `REG_OFS` (default 0xD04) returns the active vector in bits [VEC_W-1:0], the pending vector starting at bit 12, and the single-active input in bit 11. Bits 23 and 24 and every other unassigned bit read as 0.
- R3: A write with bit 26 set makes the timer pend flag 1 in the copy chosen by the access's secure attribute (1 = secure copy), and leaves the other copy unchanged.
- R4: A write with bit 25 set and bit 26 clear clears the timer pend flag of the chosen copy. When bits 25 and 26 are both 1, the flag is set.
- R5: A write with bit 28 set makes the PendSV pend flag 1 in the chosen copy. Bit 27 alone clears it, and when bits 27 and 28 are both 1 the flag is set.
- R6: Read bits 26 (timer) and 28 (PendSV) come from the secure copy when the read is secure and from the non-secure copy otherwise.
- R7: A write with bit 31 set makes NMI pend 1 only while the visibility input is 1. While that input is 0, the write has no effect on NMI pend.
- R8: In the newer mode, while the visibility input is 1, a write with bit 31 = 0 and bit 30 = 1 clears NMI pend. With bit 31 = 1 the write sets NMI pend regardless of bit 30. While visibility is 0, bit 30 has no effect. In the older mode bit 30 never has any effect.
- R9: Read bit 31 shows NMI pend while the visibility input is 1 and reads 0 while it is 0, even if NMI is pending.
- R10: A write to any other address, or a cycle with the write enable low, changes no pend flag. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access security attribute, 1 = secure |
| bus_rdata | output | 32 | Read data, combinational in the same cycle |
| act_vec | input | VEC_W | Number of the running exception |
| pend_vec | input | VEC_W | Number of the highest pending exception |
| ret_base | input | 1 | High when exactly one exception is active |
| nmi_vis | input | 1 | Non-secure visibility of NMI and fault control |
| timer_pend | output | 2 | Timer pend flags, index 1 secure, index 0 non-secure |
| sv_pend | output | 2 | PendSV pend flags, same indexing |
| nmi_pend | output | 1 | NMI pend flag |

## Verification
The case that is hardest to reach is a pend flag that differs between the two banks. The read port shows only the bank that the current access selects, so a wrong bank select could be missed. The stimulus sets a flag through one security state and then reads it back through both. This confirms that the other copy stayed 0. The same approach covers NMI status: NMI is left pending and the visibility input is then dropped, so the read shows 0 while the nmi_pend output still shows 1.

// File: rtl/ctrl_state_reg_pkg.sv
package ctrl_state_reg_pkg;

   localparam int unsigned DATA_W      = 32;
   localparam int unsigned NUM_BANKS   = 2;

   localparam int unsigned BIT_NMI_SET = 31;
   localparam int unsigned BIT_NMI_CLR = 30;
   localparam int unsigned BIT_SV_SET  = 28;
   localparam int unsigned BIT_SV_CLR  = 27;
   localparam int unsigned BIT_TM_SET  = 26;
   localparam int unsigned BIT_TM_CLR  = 25;
   localparam int unsigned BIT_BASE    = 11;
   localparam int unsigned PEND_LSB    = 12;
   localparam int unsigned MAX_VEC_W   = 9;

   typedef enum logic {
      BANK_NS = 1'b0,
      BANK_S  = 1'b1
   } bank_e;

   typedef struct packed {
      logic set;
      logic clr;
   } pend_cmd_t;

endpackage

// File: rtl/banked_pend.sv
module banked_pend
   import ctrl_state_reg_pkg::*;
#(
   parameter int unsigned BANKS = NUM_BANKS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  pend_cmd_t        cmd,
   output logic [BANKS-1:0] q
);

   localparam int unsigned SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

   generate
      if (BANKS != 2) begin : g_bad_banks
         $error("banked_pend expects exactly two security banks");
      end
   endgenerate

   logic [SEL_W-1:0] sel_idx;
   assign sel_idx = SEL_W'(sel);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (sel_idx == SEL_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[b] <= 1'b0;
         end else if (hit && cmd.set) begin
            q[b] <= 1'b1;
         end else if (hit && cmd.clr) begin
            q[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nmi_pend_ctl.sv
module nmi_pend_ctl
   import ctrl_state_reg_pkg::*;
#(
   parameter bit NEWER_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic vis,
   input  logic set_bit,
   input  logic clr_bit,
   output logic pend
);

   pend_cmd_t cmd;

   assign cmd.set = wr_hit && vis && set_bit;

   generate
      if (NEWER_MODE) begin : g_clr_newer
         assign cmd.clr = wr_hit && vis && !set_bit && clr_bit;
      end else begin : g_clr_older
         logic clr_unused;
         assign clr_unused = clr_bit;
         assign cmd.clr    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (cmd.set) begin
         pend <= 1'b1;
      end else if (cmd.clr) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/state_read_mux.sv
module state_read_mux
   import ctrl_state_reg_pkg::*;
#(
   parameter int unsigned VEC_W = 9
) (
   input  logic              rd_hit,
   input  logic              sec,
   input  logic [VEC_W-1:0]  act_vec,
   input  logic [VEC_W-1:0]  pend_vec,
   input  logic              ret_base,
   input  logic [NUM_BANKS-1:0] timer_q,
   input  logic [NUM_BANKS-1:0] sv_q,
   input  logic              nmi_q,
   input  logic              vis,
   output logic [DATA_W-1:0] rdata
);

   logic tm_sel;
   logic sv_sel;

   assign tm_sel = sec ? timer_q[BANK_S] : timer_q[BANK_NS];
   assign sv_sel = sec ? sv_q[BANK_S]    : sv_q[BANK_NS];

   always_comb begin
      rdata = '0;
      if (rd_hit) begin
         rdata[VEC_W-1:0]         = act_vec;
         rdata[PEND_LSB +: VEC_W] = pend_vec;
         rdata[BIT_BASE]          = ret_base;
         rdata[BIT_TM_SET]        = tm_sel;
         rdata[BIT_SV_SET]        = sv_sel;
         rdata[BIT_NMI_SET]       = vis && nmi_q;
      end
   end

endmodule

// File: rtl/ctrl_state_reg.sv
module ctrl_state_reg
   import ctrl_state_reg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 12,
   parameter int unsigned       VEC_W      = 9,
   parameter logic [ADDR_W-1:0] REG_OFS    = ADDR_W'('hD04),
   parameter bit                NEWER_MODE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_secure,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [VEC_W-1:0]     act_vec,
   input  logic [VEC_W-1:0]     pend_vec,
   input  logic                 ret_base,
   input  logic                 nmi_vis,
   output logic [NUM_BANKS-1:0] timer_pend,
   output logic [NUM_BANKS-1:0] sv_pend,
   output logic                 nmi_pend
);

   generate
      if (VEC_W < 1 || VEC_W > MAX_VEC_W) begin : g_bad_vec
         $error("VEC_W must lie between 1 and 9");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must be at least 12");
      end
      if (REG_OFS[1:0] != 2'b00) begin : g_bad_ofs
         $error("REG_OFS must be word aligned");
      end
   endgenerate

   logic      addr_hit;
   logic      wr_hit;
   pend_cmd_t tm_cmd;
   pend_cmd_t sv_cmd;
   logic      wdata_unused;

   assign addr_hit = (bus_addr == REG_OFS);
   assign wr_hit   = addr_hit && bus_wr;

   assign tm_cmd.set = wr_hit && bus_wdata[BIT_TM_SET];
   assign tm_cmd.clr = wr_hit && bus_wdata[BIT_TM_CLR];
   assign sv_cmd.set = wr_hit && bus_wdata[BIT_SV_SET];
   assign sv_cmd.clr = wr_hit && bus_wdata[BIT_SV_CLR];

   assign wdata_unused = ^{bus_wdata[29], bus_wdata[24:0]};

   banked_pend #(.BANKS(NUM_BANKS)) u_timer_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bus_secure),
      .cmd   (tm_cmd),
      .q     (timer_pend)
   );

   banked_pend #(.BANKS(NUM_BANKS)) u_sv_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bus_secure),
      .cmd   (sv_cmd),
      .q     (sv_pend)
   );

   nmi_pend_ctl #(.NEWER_MODE(NEWER_MODE)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .vis     (nmi_vis),
      .set_bit (bus_wdata[BIT_NMI_SET]),
      .clr_bit (bus_wdata[BIT_NMI_CLR]),
      .pend    (nmi_pend)
   );

   state_read_mux #(.VEC_W(VEC_W)) u_rd_mux (
      .rd_hit   (addr_hit),
      .sec      (bus_secure),
      .act_vec  (act_vec),
      .pend_vec (pend_vec),
      .ret_base (ret_base),
      .timer_q  (timer_pend),
      .sv_q     (sv_pend),
      .nmi_q    (nmi_pend),
      .vis      (nmi_vis),
      .rdata    (bus_rdata)
   );

endmodule

// File: rtl/ctrl_state_reg_chk.sv
module ctrl_state_reg_chk
   import ctrl_state_reg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] REG_OFS    = ADDR_W'('hD04),
   parameter bit                NEWER_MODE = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic                 bus_secure,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 nmi_vis,
   input logic [NUM_BANKS-1:0] timer_pend,
   input logic [NUM_BANKS-1:0] sv_pend,
   input logic                 nmi_pend
);

   logic wr_at_reg;
   logic chk_unused;
   assign wr_at_reg  = bus_wr && (bus_addr == REG_OFS);
   assign chk_unused = ^{bus_rdata[30:25], bus_rdata[22:0], bus_wdata[29], bus_wdata[24:0]};

   p_timer_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_at_reg && bus_wdata[BIT_TM_SET] && bus_secure |=> timer_pend[1]);

   p_other_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_secure |=> $stable(timer_pend[0]) && $stable(sv_pend[0]));

   p_timer_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_at_reg && bus_wdata[BIT_TM_CLR] && !bus_wdata[BIT_TM_SET] && !bus_secure
      |=> !timer_pend[0]);

   p_sv_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_at_reg && bus_wdata[BIT_SV_SET] && !bus_secure |=> sv_pend[0]);

   p_bank_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_OFS) && bus_secure |-> bus_rdata[BIT_SV_SET] == sv_pend[1]);

   p_nmi_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_vis |=> $stable(nmi_pend));

   p_nmi_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_at_reg && nmi_vis && bus_wdata[BIT_NMI_SET] |=> nmi_pend);

   p_nmi_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      NEWER_MODE && wr_at_reg && nmi_vis && !bus_wdata[BIT_NMI_SET] && bus_wdata[BIT_NMI_CLR]
      |=> !nmi_pend);

   p_nmi_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_vis |-> !bus_rdata[BIT_NMI_SET]);

   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[24:23] == 2'b00);

   p_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_at_reg |=> $stable(timer_pend) && $stable(sv_pend) && $stable(nmi_pend));

endmodule

bind ctrl_state_reg ctrl_state_reg_chk #(
   .ADDR_W     (ADDR_W),
   .REG_OFS    (REG_OFS),
   .NEWER_MODE (NEWER_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_secure (bus_secure),
   .bus_rdata  (bus_rdata),
   .nmi_vis    (nmi_vis),
   .timer_pend (timer_pend),
   .sv_pend    (sv_pend),
   .nmi_pend   (nmi_pend)
);

// File: tb/ctrl_state_reg_bench.sv
`timescale 1ns/1ps
module ctrl_state_reg_bench;

   localparam int unsigned AW  = 12;
   localparam int unsigned VW  = 9;
   localparam logic [AW-1:0] OFS = 12'hD04;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = OFS;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_secure = 1'b0;
   logic [31:0]   bus_rdata;
   logic [VW-1:0] act_vec = '0;
   logic [VW-1:0] pend_vec = '0;
   logic          ret_base = 1'b0;
   logic          nmi_vis = 1'b0;
   logic [1:0]    timer_pend;
   logic [1:0]    sv_pend;
   logic          nmi_pend;

   always #10 clk = ~clk;

   ctrl_state_reg u_ctrl_state_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
      .act_vec(act_vec), .pend_vec(pend_vec), .ret_base(ret_base),
      .nmi_vis(nmi_vis), .timer_pend(timer_pend), .sv_pend(sv_pend),
      .nmi_pend(nmi_pend)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [1:0] m_tm = '0;
   logic [1:0] m_sv = '0;
   logic       m_nmi = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   event        sample_ev;

   function automatic logic [31:0] model_read(logic [AW-1:0] a, logic s);
      logic [31:0] v = '0;
      if (a == OFS) begin
         v[VW-1:0]  = act_vec;
         v[12 +: VW] = pend_vec;
         v[11]      = ret_base;
         v[26]      = m_tm[s];
         v[28]      = m_sv[s];
         v[31]      = nmi_vis & m_nmi;
      end
      return v;
   endfunction

   task automatic do_write(logic [AW-1:0] a, logic s, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_secure = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      if (a == OFS) begin
         if (d[26]) m_tm[s] = 1'b1; else if (d[25]) m_tm[s] = 1'b0;
         if (d[28]) m_sv[s] = 1'b1; else if (d[27]) m_sv[s] = 1'b0;
         if (nmi_vis) begin
            if (d[31]) m_nmi = 1'b1; else if (d[30]) m_nmi = 1'b0;
         end
      end
   endtask

   task automatic check_read(logic [AW-1:0] a, logic s, string tag);
      @(negedge clk);
      bus_addr = a; bus_secure = s;
      exp_q.push_back(model_read(a, s));
      tag_q.push_back(tag);
      #5;
      -> sample_ev;
      #1;
   endtask

   task automatic check_bit(logic act, logic exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   initial begin : monitor
      forever begin
         @(sample_ev);
         if (exp_q.size() != 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   initial begin : watchdog
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_read(OFS, 1'b1, "R1 secure read after reset");
      check_read(OFS, 1'b0, "R1 non-secure read after reset");
      check_bit(nmi_pend, 1'b0, "R1 nmi_pend after reset");
      // R2: status fields
      act_vec = 9'h1A5; pend_vec = 9'h033; ret_base = 1'b1;
      check_read(OFS, 1'b0, "R2 status fields");
      act_vec = 9'h003; pend_vec = 9'h1FF; ret_base = 1'b0;
      check_read(OFS, 1'b1, "R2 status fields second pattern");
      // R10: other address reads 0
      check_read(12'hD08, 1'b1, "R10 read elsewhere");
      // R3 / R6: timer set banked
      do_write(OFS, 1'b1, 32'h0400_0000);
      check_read(OFS, 1'b1, "R3 timer set secure copy");
      check_read(OFS, 1'b0, "R3 non-secure copy untouched");
      // R6 / R5: PendSV set through non-secure
      do_write(OFS, 1'b0, 32'h1000_0000);
      check_read(OFS, 1'b0, "R6 pendsv non-secure view");
      check_read(OFS, 1'b1, "R6 pendsv secure view");
      // R4: set wins, then clear
      do_write(OFS, 1'b1, 32'h0600_0000);
      check_read(OFS, 1'b1, "R4 timer set wins over clear");
      do_write(OFS, 1'b1, 32'h0200_0000);
      check_read(OFS, 1'b1, "R4 timer clear");
      // R5: set wins, then clear
      do_write(OFS, 1'b0, 32'h1800_0000);
      check_read(OFS, 1'b0, "R5 pendsv set wins over clear");
      do_write(OFS, 1'b0, 32'h0800_0000);
      check_read(OFS, 1'b0, "R5 pendsv clear");
      // R7: hidden NMI set ignored
      nmi_vis = 1'b0;
      do_write(OFS, 1'b0, 32'h8000_0000);
      check_bit(nmi_pend, 1'b0, "R7 nmi set ignored when hidden");
      nmi_vis = 1'b1;
      do_write(OFS, 1'b0, 32'h8000_0000);
      check_bit(nmi_pend, 1'b1, "R7 nmi set when visible");
      check_read(OFS, 1'b0, "R9 nmi visible read");
      nmi_vis = 1'b0;
      check_read(OFS, 1'b0, "R9 nmi hidden read");
      check_bit(nmi_pend, 1'b1, "R9 nmi still pending while hidden");
      // R8: clear gating
      do_write(OFS, 1'b0, 32'h4000_0000);
      check_bit(nmi_pend, 1'b1, "R8 clear ignored when hidden");
      nmi_vis = 1'b1;
      do_write(OFS, 1'b1, 32'hC000_0000);
      check_bit(nmi_pend, 1'b1, "R8 set wins with both bits");
      do_write(OFS, 1'b1, 32'h4000_0000);
      check_bit(nmi_pend, 1'b0, "R8 nmi clear");
      check_read(OFS, 1'b1, "R8 nmi clear readback");
      // R10: write elsewhere and plain read cycles have no effect
      do_write(12'hD00, 1'b1, 32'hFFFF_FFFF);
      do_write(12'hD05, 1'b0, 32'hFFFF_FFFF);
      check_read(OFS, 1'b1, "R10 secure copy after stray writes");
      check_read(OFS, 1'b0, "R10 non-secure copy after stray writes");
      check_bit(nmi_pend, 1'b0, "R10 nmi after stray writes");
      check_bit(timer_pend[0], 1'b0, "R3 non-secure timer output");
      check_bit(timer_pend[1], 1'b0, "R4 secure timer output");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule